// File: doc/BRIEF.md
# TDM Codec Serial Port with Graceful Disable

This block is the master side of a time-division-multiplexed link to an audio codec. The serial bit rate is set by a one-cycle tick input: every tick ends one bit period. Each frame has a programmable number of time slots, and each slot carries a word of programmable width. Transmit words leave MSB first from a one-word transmit buffer. Receive words are assembled MSB first, parked in a shadow register, and then handed to a receive buffer that software reads. The buffer has full and overflow flags. The current slot number is visible on a port.

The block starts on the tick after the enable input goes high. It first spends one bit period on a frame-sync pulse, and then slot 0 begins. When enable is dropped, the block does not stop at once. The decision is taken at a fixed point three bit periods before the end of a frame. If enable is already low there, that frame is the last one. If it drops later, exactly one more frame runs. No new frame-sync pulse appears once enable is low. On returning to idle the block releases its pins and flushes the word left in the shadow register into the receive buffer.

Configuration (word length, slot count) may change only while the block is idle. A frame must hold at least four bit periods.

Top module: `tdm_serial_port`

## Requirements
- R1: After reset, slot is 0, pin_oe, fsync, sdo, rx_full, rx_ovf and irq are 0.
- R2: With enable high while idle, the next tick opens a one-bit-period sync period in which fsync=1 and pin_oe=1. The following tick begins slot 0, and pin_oe rises together with fsync.
- R3: A frame holds slots_m1+1 slots of word_len_m1+1 bits each. slot counts 0..slots_m1, changes only on a tick and never exceeds slots_m1. sdo carries the transmit buffer word MSB first, loaded at each slot start.
- R4: fsync is 1 during the last bit period of a frame only while enable is high and no disable has been seen; it implies pin_oe.
- R5: If enable is low at the tick ending the fourth-from-last bit period of a frame, or at any earlier tick of it, that frame is the last. Otherwise the block runs to the end of the next frame and stops there.
- R6: On the tick ending the final frame, pin_oe drops, slot returns to 0, and sdo and fsync stay 0 while idle.
- R7: Received bits (sdi sampled at each tick) form words MSB first. When a word completes, the previous shadow word moves to the receive buffer and rx_full is set.
- R8: One clock after entering idle, a word left in the shadow register is moved to the receive buffer.
- R9: A move into the receive buffer while rx_full is set and not being read sets rx_ovf; the buffer takes the new word.
- R10: irq = rx_full, or the block is active and the transmit buffer is empty.
- R11: rx_read clears rx_full and rx_ovf, unless a move happens in the same cycle, which leaves rx_full set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe ending each bit period |
| enable | input | 1 | Run request; clearing it stops after the current or next frame |
| word_len_m1 | input | LEN_W | Word length minus one |
| slots_m1 | input | SLOT_W | Slots per frame minus one |
| tx_word | input | MAXW | Word written to the transmit buffer |
| tx_write | input | 1 | Write strobe for tx_word |
| rx_read | input | 1 | Read acknowledge for the receive buffer |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| fsync | output | 1 | Frame-sync pulse |
| pin_oe | output | 1 | Output enable for sdo and fsync |
| slot | output | SLOT_W | Current slot number |
| tx_full | output | 1 | Transmit buffer holds an unsent word |
| rx_word | output | MAXW | Receive buffer contents |
| rx_full | output | 1 | Receive buffer holds an unread word |
| rx_ovf | output | 1 | Receive buffer was overwritten unread |
| irq | output | 1 | Service request |

## Verification
The checker covers the relations that hold on every cycle:
- fsync only while the pins are driven;
- a quiet, slot-zero idle;
- slot staying within range and moving only on ticks;
- pin_oe rising together with fsync;
- overflow rising only with a full buffer.

The cutoff point, the extra frame after a late disable, the bit order on both data lines, the shadow flush on entering idle and the flag clearing can only be shown by the bench. It sweeps several word/slot configurations with disables placed on both sides of the cutoff. It checks every bit period against arithmetically generated words.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_RUN  = 2'd2
    } tdm_state_e;

    typedef struct packed {
        logic load;       // tick that opens a slot
        logic shift;      // tick inside a running frame
        logic word_done;  // tick that ends a slot's last bit
    } tdm_strobe_t;

endpackage

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
    import tdm_pkg::*;
#(
    parameter int MAXW   = 16,
    parameter int SLOT_W = 4,
    localparam int LEN_W = $clog2(MAXW),
    localparam int CNT_W = LEN_W + SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enable,
    input  logic [LEN_W-1:0]  word_len_m1,
    input  logic [SLOT_W-1:0] slots_m1,
    output tdm_strobe_t       strobe,
    output logic              run,
    output logic              oe,
    output logic              fsync,
    output logic [SLOT_W-1:0] slot
);

    typedef struct packed {
        tdm_state_e        st;
        logic [SLOT_W-1:0] slot;
        logic [LEN_W-1:0]  bitn;
        logic [CNT_W-1:0]  left;
        logic              disarm;
        logic              last_fr;
    } ctrl_t;

    ctrl_t            ctl_d, ctl_q;
    logic [CNT_W-1:0] frame_bits;
    logic             dis;

    assign frame_bits = CNT_W'((int'(slots_m1) + 1) * (int'(word_len_m1) + 1));

    always_comb begin
        ctl_d  = ctl_q;
        strobe = '0;
        dis    = ctl_q.disarm || !enable;
        case (ctl_q.st)
            ST_IDLE: begin
                if (tick && enable) ctl_d.st = ST_SYNC;
            end
            ST_SYNC: begin
                if (tick) begin
                    ctl_d.st      = ST_RUN;
                    ctl_d.disarm  = dis;
                    ctl_d.slot    = '0;
                    ctl_d.bitn    = word_len_m1;
                    ctl_d.left    = frame_bits - 1'b1;
                    ctl_d.last_fr = 1'b0;
                    strobe.load   = 1'b1;
                end
            end
            default: begin
                if (tick) begin
                    strobe.shift     = 1'b1;
                    strobe.word_done = (ctl_q.bitn == '0);
                    ctl_d.disarm     = dis;
                    if (ctl_q.left == CNT_W'(3)) ctl_d.last_fr = dis;
                    if (ctl_q.left == '0) begin
                        ctl_d.slot = '0;
                        if (ctl_q.last_fr) begin
                            ctl_d.st      = ST_IDLE;
                            ctl_d.bitn    = '0;
                            ctl_d.disarm  = 1'b0;
                            ctl_d.last_fr = 1'b0;
                        end else begin
                            ctl_d.bitn    = word_len_m1;
                            ctl_d.left    = frame_bits - 1'b1;
                            ctl_d.last_fr = 1'b0;
                            strobe.load   = 1'b1;
                        end
                    end else begin
                        ctl_d.left = ctl_q.left - 1'b1;
                        if (ctl_q.bitn == '0) begin
                            ctl_d.slot  = ctl_q.slot + 1'b1;
                            ctl_d.bitn  = word_len_m1;
                            strobe.load = 1'b1;
                        end else begin
                            ctl_d.bitn = ctl_q.bitn - 1'b1;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign run   = (ctl_q.st == ST_RUN);
    assign oe    = (ctl_q.st != ST_IDLE);
    assign slot  = ctl_q.slot;
    assign fsync = (ctl_q.st == ST_SYNC) ||
                   (run && ctl_q.left == '0 && !ctl_q.last_fr && !ctl_q.disarm && enable);

endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path
    import tdm_pkg::*;
#(
    parameter int MAXW   = 16,
    localparam int LEN_W = $clog2(MAXW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tdm_strobe_t      strobe,
    input  logic             run,
    input  logic [LEN_W-1:0] word_len_m1,
    input  logic [MAXW-1:0]  tx_word,
    input  logic             tx_write,
    output logic             sdo,
    output logic             tx_full
);

    typedef struct packed {
        logic [MAXW-1:0] buf_w;
        logic            full;
        logic [MAXW-1:0] sh;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (strobe.load) begin
            tx_d.sh   = tx_q.full ? tx_q.buf_w : '0;
            tx_d.full = 1'b0;
        end else if (strobe.shift) begin
            tx_d.sh = {tx_q.sh[MAXW-2:0], 1'b0};
        end
        if (tx_write) begin
            tx_d.buf_w = tx_word;
            tx_d.full  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign sdo     = run && tx_q.sh[word_len_m1];
    assign tx_full = tx_q.full;

endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path
    import tdm_pkg::*;
#(
    parameter int MAXW   = 16,
    localparam int LEN_W = $clog2(MAXW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tdm_strobe_t      strobe,
    input  logic             idle,
    input  logic [LEN_W-1:0] word_len_m1,
    input  logic             sdi,
    input  logic             rx_read,
    output logic [MAXW-1:0]  rx_word,
    output logic             rx_full,
    output logic             rx_ovf
);

    typedef struct packed {
        logic [MAXW-1:0] sh;
        logic [MAXW-1:0] shadow;
        logic            shadow_ok;
        logic [MAXW-1:0] buf_w;
        logic            full;
        logic            ovf;
    } rx_t;

    rx_t             rx_d, rx_q;
    logic [MAXW-1:0] mask;
    logic [MAXW-1:0] move_val;
    logic            move;

    always_comb begin
        for (int i = 0; i < MAXW; i++) mask[i] = (i <= int'(word_len_m1));
    end

    always_comb begin
        rx_d     = rx_q;
        move     = 1'b0;
        move_val = rx_q.shadow;
        if (rx_read) begin
            rx_d.full = 1'b0;
            rx_d.ovf  = 1'b0;
        end
        if (strobe.shift) rx_d.sh = {rx_q.sh[MAXW-2:0], sdi};
        if (strobe.word_done) begin
            move           = rx_q.shadow_ok;
            rx_d.shadow    = {rx_q.sh[MAXW-2:0], sdi} & mask;
            rx_d.shadow_ok = 1'b1;
        end else if (idle && rx_q.shadow_ok) begin
            move           = 1'b1;
            rx_d.shadow_ok = 1'b0;
        end
        if (move) begin
            rx_d.buf_w = move_val;
            rx_d.full  = 1'b1;
            if (rx_q.full && !rx_read) rx_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign rx_word = rx_q.buf_w;
    assign rx_full = rx_q.full;
    assign rx_ovf  = rx_q.ovf;

endmodule

// File: rtl/tdm_serial_port.sv
module tdm_serial_port
    import tdm_pkg::*;
#(
    parameter int MAXW   = 16,
    parameter int SLOT_W = 4,
    localparam int LEN_W = $clog2(MAXW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              enable,
    input  logic [LEN_W-1:0]  word_len_m1,
    input  logic [SLOT_W-1:0] slots_m1,
    input  logic [MAXW-1:0]   tx_word,
    input  logic              tx_write,
    input  logic              rx_read,
    input  logic              sdi,
    output logic              sdo,
    output logic              fsync,
    output logic              pin_oe,
    output logic [SLOT_W-1:0] slot,
    output logic              tx_full,
    output logic [MAXW-1:0]   rx_word,
    output logic              rx_full,
    output logic              rx_ovf,
    output logic              irq
);

    tdm_strobe_t strobe;
    logic        run;

    tdm_frame_ctrl #(.MAXW(MAXW), .SLOT_W(SLOT_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .tick(bit_tick), .enable(enable),
        .word_len_m1(word_len_m1), .slots_m1(slots_m1),
        .strobe(strobe), .run(run), .oe(pin_oe), .fsync(fsync), .slot(slot)
    );

    tdm_tx_path #(.MAXW(MAXW)) tx_i (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .run(run),
        .word_len_m1(word_len_m1), .tx_word(tx_word), .tx_write(tx_write),
        .sdo(sdo), .tx_full(tx_full)
    );

    tdm_rx_path #(.MAXW(MAXW)) rx_i (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .idle(!pin_oe),
        .word_len_m1(word_len_m1), .sdi(sdi), .rx_read(rx_read),
        .rx_word(rx_word), .rx_full(rx_full), .rx_ovf(rx_ovf)
    );

    assign irq = rx_full || (pin_oe && !tx_full);

endmodule

// File: rtl/tdm_serial_port_chk.sv
module tdm_serial_port_chk #(
    parameter int SLOT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_tick,
    input logic [SLOT_W-1:0] slots_m1,
    input logic              fsync,
    input logic              pin_oe,
    input logic              sdo,
    input logic [SLOT_W-1:0] slot,
    input logic              rx_full,
    input logic              rx_ovf
);

    assert_fsync_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |-> pin_oe);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> (slot == '0 && !fsync && !sdo));

    assert_slot_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= slots_m1);

    assert_slot_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(slot));

    assert_start_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_oe) |-> fsync);

    assert_ovf_with_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovf) |-> rx_full);

endmodule

bind tdm_serial_port tdm_serial_port_chk #(.SLOT_W(SLOT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .slots_m1(slots_m1),
    .fsync(fsync), .pin_oe(pin_oe), .sdo(sdo), .slot(slot),
    .rx_full(rx_full), .rx_ovf(rx_ovf)
);

// File: tb/tdm_serial_port_tb.sv
`timescale 1ns/1ps
module tdm_serial_port_tb_top;

    localparam int MAXW   = 16;
    localparam int SLOT_W = 4;
    localparam int LEN_W  = $clog2(MAXW);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bit_tick = 1'b0;
    logic              enable = 1'b0;
    logic [LEN_W-1:0]  word_len_m1 = '0;
    logic [SLOT_W-1:0] slots_m1 = '0;
    logic [MAXW-1:0]   tx_word = '0;
    logic              tx_write = 1'b0;
    logic              rx_read = 1'b0;
    logic              sdi = 1'b0;
    logic              sdo, fsync, pin_oe, tx_full, rx_full, rx_ovf, irq;
    logic [SLOT_W-1:0] slot;
    logic [MAXW-1:0]   rx_word;

    int n_run = 0;
    int n_fail = 0;
    int run_id = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tdm_serial_port #(.MAXW(MAXW), .SLOT_W(SLOT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .enable(enable),
        .word_len_m1(word_len_m1), .slots_m1(slots_m1), .tx_word(tx_word),
        .tx_write(tx_write), .rx_read(rx_read), .sdi(sdi), .sdo(sdo),
        .fsync(fsync), .pin_oe(pin_oe), .slot(slot), .tx_full(tx_full),
        .rx_word(rx_word), .rx_full(rx_full), .rx_ovf(rx_ovf), .irq(irq)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (run %0d)", tag, act, exp, run_id);
        end
    endtask

    function automatic int tw(input int k, input int w);
        return (k * 37 + run_id * 11 + 5) & ((1 << w) - 1);
    endfunction

    function automatic int rg(input int k, input int w);
        return (k * 23 + run_id * 13 + 9) & ((1 << w) - 1);
    endfunction

    // One enable/disable episode. Enable drops during bit period q of the run.
    task automatic run_cfg(input int wl, input int sm, input int q, input bit rd);
        int nb = (sm + 1) * (wl + 1);
        int w = wl + 1;
        int last = 0;
        int total;
        int nwords;
        run_id++;
        while (last * nb + nb - 4 < q) last++;
        total  = (last + 1) * nb;
        nwords = total / w;
        @(negedge clk);
        word_len_m1 = LEN_W'(wl);
        slots_m1    = SLOT_W'(sm);
        tx_word     = MAXW'(tw(0, w));
        tx_write    = 1'b1;
        @(negedge clk);
        tx_write = 1'b0;
        enable   = 1'b1;
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        @(negedge clk);
        check_eq("R2 sync fsync", int'(fsync), 1);
        check_eq("R2 sync pin_oe", int'(pin_oe), 1);
        bit_tick = 1'b1;
        for (int p = 0; p < total; p++) begin
            int k = p / w;
            int b = p % w;
            @(negedge clk);
            bit_tick = 1'b0;
            if (b == 0) begin
                check_eq("R10 irq on empty tx", int'(irq), 1);
                if (rd && k >= 2) begin
                    check_eq("R7 rx_word", int'(rx_word), rg(k - 2, w));
                    check_eq("R7 rx_full", int'(rx_full), 1);
                    rx_read = 1'b1;
                end
                tx_word  = MAXW'(tw(k + 1, w));
                tx_write = 1'b1;
            end
            if (p == q) enable = 1'b0;
            sdi = rg(k, w)[w - 1 - b];
            @(negedge clk);
            bit_tick = 1'b1;
            rx_read  = 1'b0;
            tx_write = 1'b0;
            check_eq("R1 pin_oe while running", int'(pin_oe), 1);
            check_eq("R3 slot", int'(slot), (p % nb) / w);
            check_eq("R3 sdo", int'(sdo), (tw(k, w) >> (w - 1 - b)) & 1);
            check_eq("R4 fsync", int'(fsync), ((p % nb == nb - 1) && p < q) ? 1 : 0);
        end
        @(negedge clk);
        bit_tick = 1'b0;
        check_eq("R5 stopped after expected frame", int'(pin_oe), 0);
        check_eq("R6 slot zero at idle", int'(slot), 0);
        check_eq("R6 fsync quiet", int'(fsync), 0);
        if (rd) begin
            if (nwords >= 2) check_eq("R7 rx_word before flush", int'(rx_word), rg(nwords - 2, w));
            rx_read = 1'b1;
            @(negedge clk);
            rx_read = 1'b0;
            @(negedge clk);
            check_eq("R8 flushed word", int'(rx_word), rg(nwords - 1, w));
            check_eq("R11 read with move keeps full", int'(rx_full), 1);
            check_eq("R8 no overflow", int'(rx_ovf), 0);
            rx_read = 1'b1;
            @(negedge clk);
            rx_read = 1'b0;
            @(negedge clk);
            check_eq("R11 full cleared", int'(rx_full), 0);
            check_eq("R10 irq low at idle", int'(irq), 0);
        end else begin
            @(negedge clk);
            check_eq("R9 buffer overwritten", int'(rx_word), rg(nwords - 1, w));
            check_eq("R9 overflow set", int'(rx_ovf), 1);
            check_eq("R9 full set", int'(rx_full), 1);
            check_eq("R10 irq on full", int'(irq), 1);
            rx_read = 1'b1;
            @(negedge clk);
            rx_read = 1'b0;
            @(negedge clk);
            check_eq("R11 ovf cleared", int'(rx_ovf), 0);
            check_eq("R11 full cleared", int'(rx_full), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_eq("R1 slot", int'(slot), 0);
        check_eq("R1 pin_oe", int'(pin_oe), 0);
        check_eq("R1 fsync", int'(fsync), 0);
        check_eq("R1 sdo", int'(sdo), 0);
        check_eq("R1 irq", int'(irq), 0);
        check_eq("R1 rx_full", int'(rx_full), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Cutoff boundaries: q = N-4 ends this frame, q = N-3 one more.
        run_cfg(3, 3, 12, 1'b1);
        run_cfg(3, 3, 13, 1'b1);
        run_cfg(7, 1, 28, 1'b1);
        run_cfg(1, 3, 4, 1'b1);
        run_cfg(1, 3, 5, 1'b1);
        run_cfg(3, 0, 0, 1'b1);
        run_cfg(3, 0, 1, 1'b1);
        run_cfg(15, 0, 20, 1'b1);
        run_cfg(3, 1, 0, 1'b0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule